// File: doc/BRIEF.md
# Sticky and Live Status Unit with Masked Interrupt

This block gathers the status of a peripheral into one 32-bit status word and drives a single interrupt request. Some status positions are sticky. A one-cycle event pulse from the datapath sets the bit, and it stays set until software clears it. Other positions are live. They show the present level of a datapath signal, such as a FIFO fill condition, and no register access can change them. The remaining positions are reserved.

Software reaches three registers through a simple register bus with valid, write, address and data signals. The status register is read-only. The clear register is write-only: writing a 1 to a sticky position clears that bit. The mask register selects which status bits can drive the interrupt. The interrupt output is registered. It is the OR of every status bit ANDed with its mask bit.

Register word addresses on `bus_addr`: 0 is status, 1 is clear, 2 is mask, and 3 is unmapped. The sticky positions are 29, 21 and 11..0. The live positions are 20..12. Positions 31, 30 and 28..22 are reserved.

Top module: `stat_irq_unit`

## Requirements
- R1: After reset, every sticky bit and every mask bit is 0, `irq_o` is 0 and `bus_rvld` is 0.
- R2: A 1 on `evt_i` at a sticky position (29, 21, 11..0) sets that status bit at the next clock edge. The bit then stays 1, whatever happens to `evt_i`, until a clear write removes it.
- R3: Status positions 20..12 show `lvl_i` as it is in the cycle of the read request. A clear write has no effect on them.
- R4: A write to address 1 clears each sticky bit whose data bit is 1. Data bits that are 0 leave their sticky bits unchanged.
- R5: When a sticky bit gets an event pulse and a clearing write in the same cycle, the bit ends up set.
- R6: The status register (address 0) is read-only. Writes to it change nothing.
- R7: A read of the clear register (address 1) or of the unmapped address 3 returns 0.
- R8: Reserved positions (31, 30, 28..22) read as 0 in both the status and the mask register, even when `evt_i`, `lvl_i` or the write data drive 1 there.
- R9: The mask register (address 2) can be read and written. `irq_o` equals the OR over (status AND mask), registered one clock after the status word and the mask change.
- R10: A read request (`bus_vld`=1, `bus_wr`=0) produces `bus_rdata` with `bus_rvld`=1 on the following cycle only. The data is the register contents in the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Event pulses for sticky positions |
| lvl_i | input | 32 | Level signals for live positions |
| bus_vld | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvld | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
Sticky bits and the mask take their new values at the edge that ends the pulse or write cycle. Read data shows up one edge after the request, and the interrupt follows the status word by one more edge. So an event is visible in a read issued afterwards, and in `irq_o` two edges after the pulse started. The bench drives inputs on the falling edge and samples on the next falling edge after each of these edges. It checks `irq_o` both before and after the cycle in which it is due, so an extra or a missing stage is caught. Same-cycle cases are driven in a single cycle: set against clear, and a read against an event.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int unsigned SIU_DATA_W = 32;
  localparam logic [31:0] SIU_STICKY_DEF = 32'h2020_0FFF; // 29, 21, 11..0
  localparam logic [31:0] SIU_LIVE_DEF   = 32'h001F_F000; // 20..12

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_CLEAR  = 2'd1,
    REG_MASK   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/siu_sticky_bank.sv
module siu_sticky_bank #(
  parameter int unsigned          W        = 32,
  parameter logic [W-1:0]         SET_BITS = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sticky_o
);
  logic [W-1:0] sticky_q, sticky_d, evt_m;
  logic         sticky_en;

  always_comb begin
    evt_m     = evt_i & SET_BITS;
    // set is applied after clear, so a coincident event wins
    sticky_d  = evt_m | (sticky_q & ~clr_i);
    sticky_en = (|evt_m) | (|(clr_i & sticky_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sticky_q <= '0;
    else if (sticky_en) sticky_q <= sticky_d;
  end

  assign sticky_o = sticky_q;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q))); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & SET_BITS)) |=> ((sticky_q & $past(evt_i & SET_BITS)) == $past(evt_i & SET_BITS))); // R5
endmodule

// File: rtl/siu_reg_if.sv
module siu_reg_if
  import stat_irq_pkg::*;
#(
  parameter int unsigned  W          = 32,
  parameter logic [W-1:0] CLEAR_BITS = '1,
  parameter logic [W-1:0] IMPL_BITS  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_vld,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  input  logic [W-1:0] status_i,
  output logic [W-1:0] clr_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] bus_rdata,
  output logic         bus_rvld
);
  reg_sel_e     sel;
  logic         wr_req, rd_req, mask_en;
  logic [W-1:0] mask_q, mask_d, rdata_q, rdata_d;
  logic         rvld_q;

  always_comb begin
    sel     = reg_sel_e'(bus_addr);
    wr_req  = bus_vld & bus_wr;
    rd_req  = bus_vld & ~bus_wr;
    clr_o   = (wr_req && sel == REG_CLEAR) ? (bus_wdata & CLEAR_BITS) : '0;
    mask_en = wr_req && (sel == REG_MASK);
    mask_d  = bus_wdata & IMPL_BITS;
    unique case (sel)
      REG_STATUS: rdata_d = status_i & IMPL_BITS;
      REG_MASK:   rdata_d = mask_q;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      if (mask_en) mask_q  <= mask_d;
      if (rd_req)  rdata_q <= rdata_d;
      rvld_q <= rd_req;
    end
  end

  assign mask_o    = mask_q;
  assign bus_rdata = rdata_q;
  assign bus_rvld  = rvld_q;

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (sel == REG_CLEAR || sel == REG_NONE)) |=> (bus_rdata == '0)); // R7
  AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && sel == REG_STATUS) |=> ((bus_rdata & ~IMPL_BITS) == '0)); // R8
  AST_RVLD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvld); // R10
  AST_RVLD_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvld); // R10
endmodule

// File: rtl/siu_irq_gen.sv
module siu_irq_gen #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic irq_q, irq_d;

  always_comb irq_d = |(status_i & mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |=> !irq_o); // R9
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_i & mask_i)) |=> irq_o); // R9
endmodule

// File: rtl/stat_irq_unit.sv
module stat_irq_unit
  import stat_irq_pkg::*;
#(
  parameter int unsigned           DATA_W      = SIU_DATA_W,
  parameter logic [DATA_W-1:0]     STICKY_BITS = SIU_STICKY_DEF,
  parameter logic [DATA_W-1:0]     LIVE_BITS   = SIU_LIVE_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_i,
  input  logic [DATA_W-1:0] lvl_i,
  input  logic              bus_vld,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvld,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] IMPL_BITS = STICKY_BITS | LIVE_BITS;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic [DATA_W-1:0] sticky, clr, mask, status;

  siu_sticky_bank #(.W(DATA_W), .SET_BITS(STICKY_BITS)) sticky_i (
    .clk(clk), .rst_n(rst_s2_q), .evt_i(evt_i), .clr_i(clr), .sticky_o(sticky)
  );

  always_comb status = sticky | (lvl_i & LIVE_BITS);

  siu_reg_if #(.W(DATA_W), .CLEAR_BITS(STICKY_BITS), .IMPL_BITS(IMPL_BITS)) regs_i (
    .clk(clk), .rst_n(rst_s2_q), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_i(status),
    .clr_o(clr), .mask_o(mask), .bus_rdata(bus_rdata), .bus_rvld(bus_rvld)
  );

  siu_irq_gen #(.W(DATA_W)) irq_i (
    .clk(clk), .rst_n(rst_s2_q), .status_i(status), .mask_i(mask), .irq_o(irq_o)
  );

  AST_LIVE_UNCLEARED: assert property (@(posedge clk) disable iff (!rst_s2_q)
    ((clr & LIVE_BITS) == '0)); // R3
  AST_RO_STATUS_WRITE: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (bus_vld && bus_wr && bus_addr == 2'd0 && evt_i == '0) |=>
      ((sticky & $past(sticky)) == sticky) && ($stable(mask))); // R6
endmodule

// File: tb/stat_irq_unit_tb_top.sv
module stat_irq_unit_tb_top;
  localparam logic [31:0] STK = 32'h2020_0FFF;
  localparam logic [31:0] LIV = 32'h001F_F000;
  localparam logic [31:0] RSV = ~(STK | LIV);

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] evt_i, lvl_i, bus_wdata, bus_rdata;
  logic        bus_vld, bus_wr, bus_rvld, irq_o;
  logic [1:0]  bus_addr;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk; // 200 MHz

  stat_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .lvl_i(lvl_i),
    .bus_vld(bus_vld), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvld(bus_rvld),
    .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_vld = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_vld = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_vld = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_vld = 0;
    d = bus_rdata;
    chk(bus_rvld === 1'b1, "R10 rvld", {31'd0, bus_rvld}, 32'd1);
  endtask

  task automatic pulse(input logic [31:0] v);
    evt_i = v;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(irq_o === 1'b0, "R1 irq", {31'd0, irq_o}, 0);
    chk(bus_rvld === 1'b0, "R1 rvld", {31'd0, bus_rvld}, 0);
    bus_read(2'd0, d); chk(d === 0, "R1 status", d, 0);
    bus_read(2'd2, d); chk(d === 0, "R1 mask", d, 0);
    @(negedge clk);
    chk(bus_rvld === 1'b0, "R10 rvld drops", {31'd0, bus_rvld}, 0);
  endtask

  task automatic t_sticky();
    logic [31:0] d, e;
    e = 32'h2020_0801;
    pulse(e);
    bus_read(2'd0, d); chk(d === e, "R2 set", d, e);
    repeat (5) @(negedge clk);
    bus_read(2'd0, d); chk(d === e, "R2 hold", d, e);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    bus_write(2'd1, 32'h0);
    bus_read(2'd0, d); chk(d === 32'h2020_0801, "R4 zero write", d, 32'h2020_0801);
    bus_write(2'd1, 32'h2000_0001);
    bus_read(2'd0, d); chk(d === 32'h0020_0800, "R4 partial", d, 32'h0020_0800);
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd0, d); chk(d === 0, "R4 all", d, 0);
  endtask

  task automatic t_live();
    logic [31:0] d;
    lvl_i = 32'h0010_1000;
    bus_read(2'd0, d); chk(d === 32'h0010_1000, "R3 follow", d, 32'h0010_1000);
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd0, d); chk(d === 32'h0010_1000, "R3 no clear", d, 32'h0010_1000);
    lvl_i = 0;
    bus_read(2'd0, d); chk(d === 0, "R3 drop", d, 0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    lvl_i = 32'hFFFF_FFFF;
    pulse(32'hFFFF_FFFF);
    bus_read(2'd0, d); chk(d === (STK | LIV), "R8 status rsvd", d, STK | LIV);
    lvl_i = 0;
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_write(2'd2, 32'hFFFF_FFFF);
    bus_read(2'd2, d); chk(d === (STK | LIV), "R8 mask rsvd", d, STK | LIV);
    bus_write(2'd2, 0);
    @(negedge clk);
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    pulse(32'h0000_0060);
    evt_i = 32'h0000_0020;
    bus_write(2'd1, 32'h0000_0060);
    evt_i = 0;
    bus_read(2'd0, d); chk(d === 32'h20, "R5 set wins", d, 32'h20);
    bus_write(2'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read(2'd0, d); chk(d === 0, "R6 ro", d, 0);
    bus_read(2'd2, d); chk(d === 0, "R6 mask untouched", d, 0);
  endtask

  task automatic t_clrread();
    logic [31:0] d;
    pulse(32'h0000_0004);
    bus_read(2'd1, d); chk(d === 0, "R7 clear reg", d, 0);
    bus_read(2'd3, d); chk(d === 0, "R7 unmapped", d, 0);
    bus_write(2'd1, 32'h4);
  endtask

  task automatic t_capture();
    logic [31:0] d;
    evt_i = 32'h80;
    bus_read(2'd0, d);
    evt_i = 0;
    chk(d === 0, "R10 request-cycle value", d, 0);
    bus_read(2'd0, d); chk(d === 32'h80, "R10 later read", d, 32'h80);
    bus_write(2'd1, 32'h80);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    bus_write(2'd2, 32'h0001_0008);
    bus_read(2'd2, d); chk(d === 32'h0001_0008, "R9 mask rw", d, 32'h0001_0008);
    pulse(32'h10);
    @(negedge clk);
    chk(irq_o === 0, "R9 unmasked event", {31'd0, irq_o}, 0);
    pulse(32'h8);
    chk(irq_o === 0, "R9 not early", {31'd0, irq_o}, 0);
    @(negedge clk);
    chk(irq_o === 1, "R9 raised", {31'd0, irq_o}, 1);
    bus_write(2'd1, 32'h8);
    chk(irq_o === 1, "R9 still high", {31'd0, irq_o}, 1);
    @(negedge clk);
    chk(irq_o === 0, "R9 cleared", {31'd0, irq_o}, 0);
    lvl_i = 32'h0001_0000;
    @(negedge clk);
    chk(irq_o === 1, "R9 live raises", {31'd0, irq_o}, 1);
    lvl_i = 0;
    @(negedge clk);
    chk(irq_o === 0, "R9 live falls", {31'd0, irq_o}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; evt_i = 0; lvl_i = 0;
    bus_vld = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sticky();
    t_clear();
    t_live();
    t_reserved();
    t_setwins();
    t_readonly();
    t_clrread();
    t_capture();
    t_irq();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule